// File: doc/BRIEF.md
# Stride-2 Polyphase Transposed-Convolution Engine

This block computes a stride-2 transposed convolution with a 3x3 kernel and one filter. It never feeds an inserted zero to a multiplier. The result equals a plain 3x3 correlation over the map that zero insertion would give, where each real pixel x[i][j] sits at position (2i, 2j) and every other position is zero. The block never builds that map. Only the real pixels arrive, in raster order, on a valid/ready stream.

The block keeps two rows of pixels. From them it forms a 2x2 window for every input position (r, c). The nine kernel taps split into four groups, called phases, that share no tap. Each phase sums its own partial products and yields one output pixel. All four phases are computed from the same window. The four results then leave on a valid/ready stream, each tagged with its output row and column.

A build-time option uses five multiplier slices in place of nine. With it, each window takes two compute steps: the first evaluates phases A and D, the second phases B and C.

Top module: `deconv_s2k3`

## Requirements
- R1: For each window (r, c), taken in raster order, the block emits exactly four outputs in this order: (2r, 2c), (2r, 2c+1), (2r+1, 2c), (2r+1, 2c+1). Each output carries these coordinates on `out_row` and `out_col`. A handshake on any of the first three outputs of a window is followed in the next cycle by a valid output.
- R2: Phase A output (2r, 2c) = w0·x[r][c] + w2·x[r][c+1] + w6·x[r+1][c] + w8·x[r+1][c+1]. Weight index k = 3·u + v, where u is the kernel row and v the kernel column.
- R3: Phase B output (2r, 2c+1) = w1·x[r][c+1] + w7·x[r+1][c+1].
- R4: Phase C output (2r+1, 2c) = w3·x[r+1][c] + w5·x[r+1][c+1].
- R5: Phase D output (2r+1, 2c+1) = w4·x[r+1][c+1].
- R6: A pixel with row index IMG_H or column index IMG_W reads as zero.
- R7: A write on the weight port stores `wt_data` at index `wt_idx` (0 to 8) only while no frame is in progress. A frame is in progress from the first accepted pixel until the last output of that frame is accepted. Writes during a frame leave the weights unchanged.
- R8: Pixels and weights are signed two's complement of DATA_W bits. Every output is the exact signed sum, 2·DATA_W+4 bits wide, with no wrap even when all operands are at the most negative value.
- R9: With HALF_AREA=1 the outputs and their order are identical to those of the nine-slice build.
- R10: While `out_valid` is high and `out_ready` is low, the output data and coordinates hold and `out_valid` stays high.
- R11: After reset, `out_valid` is low and `in_ready` is high.
- R12: When the last output of a frame is accepted, the block returns to idle. It accepts weight writes again, and the next pixel starts a new frame at (0, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_we | input | 1 | Weight write strobe |
| wt_idx | input | 4 | Weight index, 3·row + column |
| wt_data | input | DATA_W | Signed weight value |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when valid |
| in_pixel | input | DATA_W | Signed input pixel, raster order |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 2·DATA_W+4 | Signed output pixel |
| out_row | output | clog2(2·IMG_H) | Output row coordinate |
| out_col | output | clog2(2·IMG_W) | Output column coordinate |

## Verification
The bench builds two copies with DATA_W=8 on a 4x5 map, one with nine slices and one with five slices over two steps. Both take the same frames, and a scoreboard compares them against a reference built by explicit zero insertion followed by ordinary correlation. The odd width of 5 puts the right edge at a column count that is not a power of two. The four rows make the two-row buffer reuse each slot twice per frame. Under differing output stall patterns, all-minimum operands reach the widest sums. A weight write during a frame and a reload between frames exercise the write gating.

// File: rtl/deconv_pkg.sv
package deconv_pkg;

    localparam int KDIM  = 3;
    localparam int NTAP  = KDIM * KDIM;
    localparam int NMODE = 4;
    localparam int NPOS  = 4;

    typedef enum logic [1:0] {
        ENG_WAIT  = 2'd0,
        ENG_STEP1 = 2'd1,
        ENG_EMIT  = 2'd2
    } eng_state_e;

    // Tap driven by a slice in a given step; -1 marks a zero-padded slice.
    function automatic int slice_tap(bit half, int step, int s);
        int t;
        t = -1;
        if (!half) begin
            if (step == 0) t = s;
        end else if (step == 0) begin
            case (s)
                0: t = 0;
                1: t = 2;
                2: t = 6;
                3: t = 8;
                4: t = 4;
                default: t = -1;
            endcase
        end else begin
            case (s)
                0: t = 1;
                1: t = 7;
                2: t = 3;
                3: t = 5;
                default: t = -1;
            endcase
        end
        return t;
    endfunction

    // Phase of a tap: odd kernel row selects the lower output row, odd column the right one.
    function automatic int tap_mode(int t);
        int u;
        int v;
        u = t / KDIM;
        v = t % KDIM;
        return ((u == 1) ? 2 : 0) + ((v == 1) ? 1 : 0);
    endfunction

    // Window pixel feeding a tap: 0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right.
    function automatic int tap_pos(int t);
        int u;
        int v;
        u = t / KDIM;
        v = t % KDIM;
        return ((u != 0) ? 2 : 0) + ((v != 0) ? 1 : 0);
    endfunction

    // Step in which a phase completes.
    function automatic int mode_step(bit half, int m);
        return (half && (m == 1 || m == 2)) ? 1 : 0;
    endfunction

endpackage

// File: rtl/deconv_wbank.sv
module deconv_wbank
    import deconv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [3:0]                       idx,
    input  logic [DATA_W-1:0]                data,
    input  logic                             busy,
    output logic [NTAP-1:0][DATA_W-1:0]      wts
);

    localparam logic [3:0] IDX_END = 4'(NTAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            wts <= '0;
        end else if (we && !busy && (idx < IDX_END)) begin
            wts[idx] <= data;
        end
    end

    // R7: weights frozen while a frame runs
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wts));

endmodule

// File: rtl/deconv_ctrl.sv
module deconv_ctrl #(
    parameter int DATA_W = 8,
    parameter int IMG_H  = 4,
    parameter int IMG_W  = 5,
    localparam int RW    = $clog2(IMG_H + 1),
    localparam int CW    = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_pixel,
    output logic                    in_ready,
    input  logic                    win_adv,
    output logic                    win_ready,
    output logic [RW-1:0]           win_row,
    output logic [CW-1:0]           win_col,
    output logic [3:0][DATA_W-1:0]  win_px,
    output logic                    busy
);

    localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
    localparam logic [RW-1:0] ROW_END  = RW'(IMG_H);
    localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);

    logic [RW-1:0]     in_row;
    logic [CW-1:0]     in_col;
    logic [DATA_W-1:0] lbuf [2][IMG_W];
    logic [RW-1:0]     need_row;
    logic [CW-1:0]     need_col;
    logic              row_edge;
    logic              col_edge;
    logic              top_s;
    logic              bot_s;
    logic              take;

    assign row_edge = (win_row == ROW_LAST);
    assign col_edge = (win_col == COL_LAST);
    assign need_row = row_edge ? win_row : win_row + RW'(1);
    assign need_col = col_edge ? win_col : win_col + CW'(1);

    // A window is computable once its bottom-right pixel (or the edge) has arrived.
    assign win_ready = (in_row > need_row) || ((in_row == need_row) && (in_col > need_col));

    // Input may run at most one row ahead of the window's bottom row: two row slots.
    assign in_ready = (in_row != ROW_END) && (in_row <= win_row + RW'(1));
    assign take     = in_valid && in_ready;
    assign busy     = (in_row != '0) || (in_col != '0);

    assign top_s = win_row[0];
    assign bot_s = ~win_row[0];

    always_comb begin
        win_px[0] = lbuf[top_s][win_col];
        win_px[1] = col_edge ? '0 : lbuf[top_s][need_col];
        win_px[2] = row_edge ? '0 : lbuf[bot_s][win_col];
        win_px[3] = (row_edge || col_edge) ? '0 : lbuf[bot_s][need_col];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_row  <= '0;
            in_col  <= '0;
            win_row <= '0;
            win_col <= '0;
        end else if (win_adv && row_edge && col_edge) begin
            in_row  <= '0;
            in_col  <= '0;
            win_row <= '0;
            win_col <= '0;
        end else begin
            if (take) begin
                if (in_col == COL_LAST) begin
                    in_col <= '0;
                    in_row <= in_row + RW'(1);
                end else begin
                    in_col <= in_col + CW'(1);
                end
            end
            if (win_adv) begin
                if (col_edge) begin
                    win_col <= '0;
                    win_row <= win_row + RW'(1);
                end else begin
                    win_col <= win_col + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            lbuf[in_row[0]][in_col] <= in_pixel;
        end
    end

    // R12: the window never overtakes the input
    a_r12_window_behind: assert property (@(posedge clk) disable iff (rst)
        win_row <= in_row);

endmodule

// File: rtl/deconv_slices.sv
module deconv_slices
    import deconv_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter bit HALF_AREA = 1'b0,
    localparam int ACC_W    = 2 * DATA_W + 4,
    localparam int NSLICE   = HALF_AREA ? 5 : NTAP
) (
    input  logic                          step,
    input  logic [NTAP-1:0][DATA_W-1:0]   wts,
    input  logic [NPOS-1:0][DATA_W-1:0]   px,
    output logic [NMODE-1:0][ACC_W-1:0]   mode_sum,
    output logic [NMODE-1:0]              mode_en
);

    logic [NSLICE-1:0][ACC_W-1:0] contrib;
    logic [NSLICE-1:0][1:0]       smode;
    logic [NSLICE-1:0]            son;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        localparam int T0  = slice_tap(HALF_AREA, 0, s);
        localparam int T1  = slice_tap(HALF_AREA, 1, s);
        localparam int T0I = (T0 < 0) ? 0 : T0;
        localparam int T1I = (T1 < 0) ? 0 : T1;
        localparam bit V0  = (T0 >= 0);
        localparam bit V1  = (T1 >= 0);
        localparam logic [1:0] M0 = 2'(tap_mode(T0I));
        localparam logic [1:0] M1 = 2'(tap_mode(T1I));
        localparam int P0  = tap_pos(T0I);
        localparam int P1  = tap_pos(T1I);

        logic signed [DATA_W-1:0]   wsel;
        logic signed [DATA_W-1:0]   psel;
        logic signed [2*DATA_W-1:0] prod;

        assign wsel       = step ? wts[T1I] : wts[T0I];
        assign psel       = step ? px[P1]   : px[P0];
        assign smode[s]   = step ? M1 : M0;
        assign son[s]     = step ? V1 : V0;
        assign prod       = wsel * psel;
        assign contrib[s] = son[s] ? ACC_W'(prod) : '0;
    end

    always_comb begin
        for (int m = 0; m < NMODE; m++) begin
            mode_sum[m] = '0;
            for (int s = 0; s < NSLICE; s++) begin
                if (son[s] && (smode[s] == 2'(m))) begin
                    mode_sum[m] = mode_sum[m] + contrib[s];
                end
            end
            mode_en[m] = (mode_step(HALF_AREA, m) == (step ? 1 : 0));
        end
    end

endmodule

// File: rtl/deconv_s2k3.sv
module deconv_s2k3
    import deconv_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int IMG_H     = 4,
    parameter int IMG_W     = 5,
    parameter bit HALF_AREA = 1'b0,
    localparam int ACC_W    = 2 * DATA_W + 4,
    localparam int ORW      = $clog2(2 * IMG_H),
    localparam int OCW      = $clog2(2 * IMG_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_we,
    input  logic [3:0]        wt_idx,
    input  logic [DATA_W-1:0] wt_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_pixel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ACC_W-1:0]  out_data,
    output logic [ORW-1:0]    out_row,
    output logic [OCW-1:0]    out_col
);

    localparam int RW = $clog2(IMG_H + 1);
    localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;

    eng_state_e                   state;
    logic [1:0]                   idx;
    logic [NMODE-1:0][ACC_W-1:0]  res;
    logic [NTAP-1:0][DATA_W-1:0]  wts;
    logic [NPOS-1:0][DATA_W-1:0]  win_px;
    logic [NMODE-1:0][ACC_W-1:0]  mode_sum;
    logic [NMODE-1:0]             mode_en;
    logic [RW-1:0]                win_row;
    logic [CW-1:0]                win_col;
    logic                         win_ready;
    logic                         win_adv;
    logic                         busy;
    logic                         step;
    logic                         fire;

    deconv_ctrl #(
        .DATA_W (DATA_W),
        .IMG_H  (IMG_H),
        .IMG_W  (IMG_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_pixel  (in_pixel),
        .in_ready  (in_ready),
        .win_adv   (win_adv),
        .win_ready (win_ready),
        .win_row   (win_row),
        .win_col   (win_col),
        .win_px    (win_px),
        .busy      (busy)
    );

    deconv_wbank #(
        .DATA_W (DATA_W)
    ) u_wbank (
        .clk  (clk),
        .rst  (rst),
        .we   (wt_we),
        .idx  (wt_idx),
        .data (wt_data),
        .busy (busy),
        .wts  (wts)
    );

    deconv_slices #(
        .DATA_W    (DATA_W),
        .HALF_AREA (HALF_AREA)
    ) u_slices (
        .step     (step),
        .wts      (wts),
        .px       (win_px),
        .mode_sum (mode_sum),
        .mode_en  (mode_en)
    );

    assign step      = (state == ENG_STEP1);
    assign fire      = ((state == ENG_WAIT) && win_ready) || (state == ENG_STEP1);
    assign out_valid = (state == ENG_EMIT);
    assign out_data  = res[idx];
    assign out_row   = ORW'({win_row, idx[1]});
    assign out_col   = OCW'({win_col, idx[0]});
    assign win_adv   = out_valid && out_ready && (idx == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_WAIT;
            idx   <= '0;
            res   <= '0;
        end else begin
            if (fire) begin
                for (int m = 0; m < NMODE; m++) begin
                    if (mode_en[m]) res[m] <= mode_sum[m];
                end
            end
            case (state)
                ENG_WAIT: begin
                    if (win_ready) state <= HALF_AREA ? ENG_STEP1 : ENG_EMIT;
                end
                ENG_STEP1: state <= ENG_EMIT;
                ENG_EMIT: begin
                    if (out_ready) begin
                        if (idx == 2'd3) begin
                            idx   <= '0;
                            state <= ENG_WAIT;
                        end else begin
                            idx <= idx + 2'd1;
                        end
                    end
                end
                default: state <= ENG_WAIT;
            endcase
        end
    end

    // R10: stalled output holds
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_row) && $stable(out_col));

    // R1: the four phases of a window leave back to back
    a_r1_burst: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !(out_row[0] && out_col[0]) |=> out_valid);

    // R1: coordinates stay inside the upsampled map
    a_r1_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_row) < 2 * IMG_H) && (int'(out_col) < 2 * IMG_W));

endmodule

// File: tb/test_deconv_s2k3.sv
module test_deconv_s2k3;

    localparam int DW  = 8;
    localparam int H   = 4;
    localparam int W   = 5;
    localparam int ACC = 2 * DW + 4;
    localparam int ORW = $clog2(2 * H);
    localparam int OCW = $clog2(2 * W);

    typedef struct {
        int d;
        int r;
        int c;
    } exp_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst;
    logic           wt_we;
    logic [3:0]     wt_idx;
    logic [DW-1:0]  wt_data;
    logic           in_valid  [2];
    logic [DW-1:0]  in_pixel  [2];
    logic           in_ready  [2];
    logic           out_valid [2];
    logic           out_ready [2];
    logic [ACC-1:0] out_data  [2];
    logic [ORW-1:0] out_row   [2];
    logic [OCW-1:0] out_col   [2];

    exp_t  q0[$];
    exp_t  q1[$];
    int    img [H][W];
    int    wts [9];
    int    n_chk;
    int    n_fail;
    int    seed;
    int    cyc;
    string ftag;
    bit             stall_prev [2];
    logic [ACC-1:0] stall_d    [2];
    logic [ORW-1:0] stall_r    [2];
    logic [OCW-1:0] stall_c    [2];

    deconv_s2k3 #(.DATA_W(DW), .IMG_H(H), .IMG_W(W), .HALF_AREA(1'b0)) i_deconv_s2k3 (
        .clk(clk), .rst(rst), .wt_we(wt_we), .wt_idx(wt_idx), .wt_data(wt_data),
        .in_valid(in_valid[0]), .in_ready(in_ready[0]), .in_pixel(in_pixel[0]),
        .out_valid(out_valid[0]), .out_ready(out_ready[0]), .out_data(out_data[0]),
        .out_row(out_row[0]), .out_col(out_col[0]));

    deconv_s2k3 #(.DATA_W(DW), .IMG_H(H), .IMG_W(W), .HALF_AREA(1'b1)) i_deconv_s2k3_half (
        .clk(clk), .rst(rst), .wt_we(wt_we), .wt_idx(wt_idx), .wt_data(wt_data),
        .in_valid(in_valid[1]), .in_ready(in_ready[1]), .in_pixel(in_pixel[1]),
        .out_valid(out_valid[1]), .out_ready(out_ready[1]), .out_data(out_data[1]),
        .out_row(out_row[1]), .out_col(out_col[1]));

    function automatic int next_val(inout int s);
        s = s * 1103515245 + 12345;
        return ((s >>> 16) & 255) - 128;
    endfunction

    // Reference: explicit zero insertion, then plain 3x3 correlation.
    task automatic push_expected();
        int up [2*H+2][2*W+2];
        exp_t e;
        for (int p = 0; p < 2*H+2; p++)
            for (int q = 0; q < 2*W+2; q++)
                up[p][q] = 0;
        for (int i = 0; i < H; i++)
            for (int j = 0; j < W; j++)
                up[2*i][2*j] = img[i][j];
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                for (int m = 0; m < 4; m++) begin
                    e.r = 2*r + m/2;
                    e.c = 2*c + m%2;
                    e.d = 0;
                    for (int u = 0; u < 3; u++)
                        for (int v = 0; v < 3; v++)
                            e.d += up[e.r+u][e.c+v] * wts[3*u+v];
                    q0.push_back(e);
                    q1.push_back(e);
                end
            end
        end
    endtask

    task automatic load_weights();
        for (int k = 0; k < 9; k++) begin
            @(posedge clk); #1;
            wt_we   = 1'b1;
            wt_idx  = 4'(k);
            wt_data = DW'(wts[k]);
        end
        @(posedge clk); #1;
        wt_we = 1'b0;
    endtask

    task automatic drive(input int k);
        for (int i = 0; i < H; i++) begin
            for (int j = 0; j < W; j++) begin
                in_valid[k] = 1'b1;
                in_pixel[k] = DW'(img[i][j]);
                do @(negedge clk); while (!in_ready[k]);
                @(posedge clk); #1;
            end
        end
        in_valid[k] = 1'b0;
    endtask

    task automatic run_frame(input string t, input bit poke);
        ftag = t;
        load_weights();
        push_expected();
        fork
            drive(0);
            drive(1);
            begin
                if (poke) begin
                    // R7: write during the frame must not land
                    repeat (12) @(posedge clk);
                    #1;
                    wt_we   = 1'b1;
                    wt_idx  = 4'd4;
                    wt_data = 8'h55;
                    @(posedge clk); #1;
                    wt_we = 1'b0;
                end
            end
        join
        while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R12: back to idle after the last output
        for (int k = 0; k < 2; k++) begin
            n_chk++;
            if (!in_ready[k] || out_valid[k]) begin
                n_fail++;
                $display("FAIL R12 dut%0d idle: in_ready=%0b out_valid=%0b exp 1/0", k, in_ready[k], out_valid[k]);
            end
        end
    endtask

    task automatic mon(input int k);
        exp_t  e;
        string mtag;
        int    got;
        if (stall_prev[k]) begin
            n_chk++;
            if (!out_valid[k] || out_data[k] != stall_d[k] || out_row[k] != stall_r[k] || out_col[k] != stall_c[k]) begin
                n_fail++;
                $display("FAIL R10 dut%0d stall hold: valid=%0b data=%0d exp %0d", k, out_valid[k],
                         $signed(out_data[k]), $signed(stall_d[k]));
            end
        end
        if (out_valid[k] && out_ready[k]) begin
            n_chk++;
            if ((k == 0 && q0.size() == 0) || (k == 1 && q1.size() == 0)) begin
                n_fail++;
                $display("FAIL R1 dut%0d unexpected output (%0d,%0d) exp none", k, out_row[k], out_col[k]);
            end else begin
                e = (k == 0) ? q0.pop_front() : q1.pop_front();
                if (int'(out_row[k]) != e.r || int'(out_col[k]) != e.c) begin
                    n_fail++;
                    $display("FAIL R1 dut%0d coord (%0d,%0d) exp (%0d,%0d)", k, out_row[k], out_col[k], e.r, e.c);
                end
                case ((e.r % 2) * 2 + (e.c % 2))
                    0: mtag = "R2";
                    1: mtag = "R3";
                    2: mtag = "R4";
                    default: mtag = "R5";
                endcase
                if (e.r / 2 == H - 1 || e.c / 2 == W - 1) mtag = {mtag, "/R6"};
                got = int'($signed(out_data[k]));
                n_chk++;
                if (got != e.d) begin
                    n_fail++;
                    $display("FAIL %s/%s%s dut%0d (%0d,%0d) got %0d exp %0d", mtag, ftag,
                             (k == 1) ? "/R9" : "", k, e.r, e.c, got, e.d);
                end
            end
        end
        stall_prev[k] = out_valid[k] && !out_ready[k] && !rst;
        stall_d[k]    = out_data[k];
        stall_r[k]    = out_row[k];
        stall_c[k]    = out_col[k];
    endtask

    always @(negedge clk) begin
        mon(0);
        mon(1);
    end

    // Downstream stall patterns, different per copy (R10).
    initial begin
        cyc = 0;
        out_ready[0] = 1'b1;
        out_ready[1] = 1'b1;
        forever begin
            @(posedge clk); #1;
            cyc++;
            out_ready[0] = (cyc % 3) != 2;
            out_ready[1] = (cyc % 4) != 1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired, outputs pending %0d/%0d exp 0", q0.size(), q1.size());
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        n_chk = 0;
        n_fail = 0;
        seed = 7;
        ftag = "R1";
        rst = 1'b1;
        wt_we = 1'b0;
        wt_idx = '0;
        wt_data = '0;
        stall_prev[0] = 1'b0;
        stall_prev[1] = 1'b0;
        for (int k = 0; k < 2; k++) begin
            in_valid[k] = 1'b0;
            in_pixel[k] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        for (int k = 0; k < 2; k++) begin
            n_chk++;
            if (out_valid[k] || !in_ready[k]) begin
                n_fail++;
                $display("FAIL R11 dut%0d after reset: out_valid=%0b in_ready=%0b exp 0/1", k, out_valid[k], in_ready[k]);
            end
        end

        // Distinct small weights and a ramp: tap mapping R2..R5, edges R6.
        for (int k = 0; k < 9; k++) wts[k] = k - 4 + ((k == 4) ? 9 : 0);
        for (int i = 0; i < H; i++)
            for (int j = 0; j < W; j++)
                img[i][j] = i * W + j - 7;
        run_frame("R2", 1'b0);

        // Pseudo-random signed operands.
        for (int k = 0; k < 9; k++) wts[k] = next_val(seed);
        for (int i = 0; i < H; i++)
            for (int j = 0; j < W; j++)
                img[i][j] = next_val(seed);
        run_frame("R1", 1'b0);

        // R8: most negative operands everywhere.
        for (int k = 0; k < 9; k++) wts[k] = -128;
        for (int i = 0; i < H; i++)
            for (int j = 0; j < W; j++)
                img[i][j] = -128;
        run_frame("R8", 1'b0);

        // R7: mid-frame write to the centre tap is ignored.
        for (int k = 0; k < 9; k++) wts[k] = (k % 2 == 0) ? -128 : 127;
        for (int i = 0; i < H; i++)
            for (int j = 0; j < W; j++)
                img[i][j] = 127 - 50 * ((i + j) % 3);
        run_frame("R7", 1'b1);

        // R12: reload between frames takes effect on the next frame.
        for (int k = 0; k < 9; k++) wts[k] = next_val(seed);
        for (int i = 0; i < H; i++)
            for (int j = 0; j < W; j++)
                img[i][j] = next_val(seed);
        run_frame("R12", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule